// File: doc/BRIEF.md
# Cascaded Sub-Interrupt Aggregator

This block gathers 32 peripheral interrupt sources into three group summary lines that feed one input each of a top-level interrupt controller. Every source passes through a two-flop synchroniser. Most sources are level-sensitive, and their status bit simply follows the synchronised input. Three sources are edge-sensitive. A rising edge on one of them latches its status bit, and the bit stays set until software clears it.

Software sees two registers through a simple synchronous port. One is the status word and the other is the mask word. A group line is high when any source in its group is both pending and enabled by the mask. The block also reports the lowest-numbered source that is pending and enabled, together with a valid flag. A handler can therefore jump straight to the right source without scanning the status word.

Top module: `subirq_aggregator`

## Requirements
- R1: Address 0 reads the status word and address 1 reads the mask word. `rd_data_o` is combinational from `addr_i`. A write with `wr_en_i` high takes effect at the next rising clock edge.
- R2: While reset is applied, and right after it is released with all sources low, the mask reads 0, the status reads 0, `grp_irq_o` is 000, `pend_valid_o` is 0 and `pend_idx_o` is 0.
- R3: Sources 16, 22 and 28 are edge-sensitive. A low-to-high change on one of these inputs sets its status bit within four rising clock edges. The bit stays set while the input stays high or falls again.
- R4: All other sources are level-sensitive. Their status bit equals the input once the input has been stable for three rising clock edges.
- R5: A status write (address 0) clears each edge-sensitive status bit whose data bit is 0. It leaves edge bits written with 1 unchanged. It has no effect on level-sensitive bits.
- R6: `grp_irq_o[0]` is the OR of (status AND mask) over bits 0 to 7. `grp_irq_o[1]` covers bits 8 to 15, and `grp_irq_o[2]` covers bits 16 to 31.
- R7: `pend_idx_o` is the index of the lowest-numbered set bit of (status AND mask).
- R8: `pend_valid_o` is 1 exactly when (status AND mask) is nonzero. When it is 0, `pend_idx_o` reads 0.
- R9: A mask write (address 1) replaces the whole mask word. The new value shows on the group lines and the index from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Raw interrupt source inputs, asynchronous |
| addr_i | input | 1 | Register select: 0 status, 1 mask |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for the selected register |
| grp_irq_o | output | 3 | Group summary lines (bits 0-7, 8-15, 16-31) |
| pend_idx_o | output | 5 | Lowest pending enabled source index |
| pend_valid_o | output | 1 | Some enabled source is pending |

## Verification
The assertions assume that an edge-sensitive input holds each level for at least two clock cycles. A shorter pulse can fall between synchroniser samples and is not required to be caught. The stimulus holds every source pattern for several cycles before it moves on. It never issues a status clear in the same cycle that an edge arrives, so the expected edge status is never ambiguous. The random patterns toggle the edge bits often, so that both rising and falling inputs meet latched and cleared status.

// File: rtl/subirq_pkg.sv
package subirq_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned IDXW = $clog2(NSRC);
  localparam int unsigned NGRP = 3;

  // sources that latch on a rising input: 16, 22, 28
  localparam logic [NSRC-1:0] EDGE_SRC = 32'h1041_0000;

  localparam int GRP_LO [NGRP] = '{0, 8, 16};
  localparam int GRP_HI [NGRP] = '{7, 15, 31};

  typedef enum logic {SEL_STAT = 1'b0, SEL_MASK = 1'b1} reg_sel_e;

  function automatic logic [NSRC-1:0] span_mask(input int lo, input int hi);
    logic [NSRC-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/subirq_rst_sync.sv
module subirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/subirq_status_bank.sv
module subirq_status_bank #(
  parameter int unsigned          N       = 32,
  parameter logic [N-1:0]         EDGE_MK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_data_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] sync1_q, sync2_q, prev_q;
  logic [N-1:0] latch_q, latch_d;
  logic [N-1:0] rise;
  logic [N-1:0] keep;

  always_comb begin
    rise    = sync2_q & ~prev_q & EDGE_MK;
    keep    = clr_en_i ? clr_data_i : {N{1'b1}};
    // a new edge wins over a clear in the same cycle
    latch_d = ((latch_q & keep) | rise) & EDGE_MK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      latch_q <= latch_d;
    end
  end

  assign status_o = (sync2_q & ~EDGE_MK) | latch_q;

  // R3: a detected rise shows in the status the next cycle
  a_r3_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((status_o & $past(rise)) == $past(rise)));

  // R5: a latched edge bit stays set unless a status clear arrives
  a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en_i |=> ((status_o & $past(status_o & EDGE_MK)) == $past(status_o & EDGE_MK)));

  // R4: level bits carry the first synchroniser stage one cycle later
  a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~EDGE_MK) == ($past(sync1_q) & ~EDGE_MK)));
endmodule

// File: rtl/subirq_group_or.sv
module subirq_group_or
  import subirq_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  output logic [NGRP-1:0] grp_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [NSRC-1:0] SPAN = span_mask(GRP_LO[g], GRP_HI[g]);
    assign grp_o[g] = |(pend_i & SPAN);
  end
endmodule

// File: rtl/subirq_lowest_first.sv
module subirq_lowest_first #(
  parameter int unsigned N = 32,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         valid_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end

  assign valid_o = |vec_i;
endmodule

// File: rtl/subirq_aggregator.sv
module subirq_aggregator
  import subirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            addr_i,
  input  logic            wr_en_i,
  input  logic [NSRC-1:0] wr_data_i,
  output logic [NSRC-1:0] rd_data_o,
  output logic [NGRP-1:0] grp_irq_o,
  output logic [IDXW-1:0] pend_idx_o,
  output logic            pend_valid_o
);
  logic            rst_i_n;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            mask_we, stat_we;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] pend;

  subirq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign mask_we = wr_en_i && (reg_sel_e'(addr_i) == SEL_MASK);
  assign stat_we = wr_en_i && (reg_sel_e'(addr_i) == SEL_STAT);

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mask_q <= '0;
    else          mask_q <= mask_d;
  end

  subirq_status_bank #(.N(NSRC), .EDGE_MK(EDGE_SRC)) u_bank (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .src_i      (src_i),
    .clr_en_i   (stat_we),
    .clr_data_i (wr_data_i),
    .status_o   (status)
  );

  assign pend = status & mask_q;

  subirq_group_or u_grp (.pend_i(pend), .grp_o(grp_irq_o));

  subirq_lowest_first #(.N(NSRC)) u_prio (
    .vec_i   (pend),
    .idx_o   (pend_idx_o),
    .valid_o (pend_valid_o)
  );

  assign rd_data_o = (reg_sel_e'(addr_i) == SEL_MASK) ? mask_q : status;

  // R9: a mask write lands whole on the next cycle
  a_r9_mask_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    mask_we |=> (mask_q == $past(wr_data_i)));

  // R7: the reported index is pending and nothing below it is
  a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_i_n)
    pend_valid_o |-> (pend[pend_idx_o] &&
      ((pend & ((NSRC'(1) << pend_idx_o) - NSRC'(1))) == '0)));

  // R8: valid agrees with the group lines, index parks at zero otherwise
  a_r8_valid_groups: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pend_valid_o == (grp_irq_o != '0)) && (pend_valid_o || pend_idx_o == '0));
endmodule

// File: tb/tb_subirq_aggregator.sv
`timescale 1ns/1ps
module tb_subirq_aggregator;
  localparam logic [31:0] EDGE = 32'h1041_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [2:0]  grp;
  logic [4:0]  idx;
  logic        valid;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_latch;
  logic [31:0] exp_mask;

  always #2.5 clk = ~clk;

  subirq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .grp_irq_o(grp),
    .pend_idx_o(idx), .pend_valid_o(valid)
  );

  function automatic logic [2:0] f_grp(input logic [31:0] p);
    return {|p[31:16], |p[15:8], |p[7:0]};
  endfunction

  function automatic logic [4:0] f_idx(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic reg_wr(input logic a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] v);
    exp_latch = exp_latch | (v & ~src & EDGE);
    src = v;
    step(5);
  endtask

  task automatic clear_stat(input logic [31:0] d);
    reg_wr(1'b0, d);
    exp_latch = exp_latch & (d | ~EDGE);
  endtask

  task automatic set_mask(input logic [31:0] d);
    reg_wr(1'b1, d);
    exp_mask = d;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] st, p;
    st = (src & ~EDGE) | exp_latch;
    p  = st & exp_mask;
    addr = 1'b0; #0.5;
    chk({"R1/R3/R4/R5 status ", tag}, rd_data, st);
    addr = 1'b1; #0.5;
    chk({"R1/R9 mask ", tag}, rd_data, exp_mask);
    chk({"R6 groups ", tag}, {29'd0, grp}, {29'd0, f_grp(p)});
    chk({"R7 index ", tag}, {27'd0, idx}, {27'd0, f_idx(p)});
    chk({"R8 valid ", tag}, {31'd0, valid}, {31'd0, (p != 0)});
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; src = '0; addr = 1'b0; wr_en = 1'b0; wr_data = '0;
    exp_latch = '0; exp_mask = '0;
    step(4);
    // R2: state while reset is held
    addr = 1'b1; #0.5; chk("R2 mask in reset", rd_data, 32'd0);
    addr = 1'b0; #0.5; chk("R2 status in reset", rd_data, 32'd0);
    chk("R2 outputs in reset", {23'd0, grp, idx, valid}, 32'd0);
    rst_n = 1'b1;
    step(4);
    check_all("R2 after reset");

    // R9 / R6: open every source
    set_mask(32'hFFFF_FFFF);
    check_all("R9 mask all");

    // R3: rising edge on bit 16 latches; still held after the input falls
    set_src(32'h0001_0000); check_all("R3 rise 16");
    set_src(32'h0000_0000); check_all("R3 hold after fall");
    // R5: writing one keeps it, writing zero clears it
    clear_stat(32'hFFFF_FFFF); check_all("R5 write one keeps");
    clear_stat(32'h0000_0000); step(1); check_all("R5 write zero clears");
    // R5: clear while input still high does not re-latch
    set_src(32'h1000_0000); clear_stat(32'hEFFF_FFFF); step(2);
    check_all("R5 clear with input high");
    // R5: writes to level bits ignored
    set_src(32'h0000_00F0); clear_stat(32'h0000_0000); step(1);
    check_all("R5 level write ignored");

    // R7 boundaries
    set_src(32'h8000_0000); check_all("R7 only bit 31");
    set_src(32'h8000_0001); check_all("R7 bits 0 and 31");
    set_src(32'h0000_0180); check_all("R6 bits 7 and 8");
    set_mask(32'h0000_0100); check_all("R6 only group 1 open");
    set_src(32'h0001_8000); set_mask(32'h0001_0000); check_all("R6 bits 15 16");
    // R8: nothing enabled
    set_mask(32'h0000_0000); check_all("R8 mask zero");
    clear_stat(32'h0); step(1);

    // random mix
    for (int k = 0; k < 300; k++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0, 1: set_src($urandom ^ ($urandom & EDGE));
        2:    set_mask($urandom);
        default: begin clear_stat($urandom); step(1); end
      endcase
      check_all("R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule